// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

The block is an 8-bit up-counter that software can load at any time. Each increment comes from one of two sources. The first is a one-cycle enable that marks the instruction-cycle clock. The second is an edge on an external pin, after that pin has passed through a synchronizer, and a select input picks the rising or the falling edge. One prescaler can sit between the chosen source and the counter, and a single routing bit decides its use: it either divides the timer's source, or it divides a watchdog tick stream while the timer counts undivided.

When the counter wraps from FFh to 00h it produces a single-cycle pulse and sets a sticky flag, which software clears. A load of the counter also resets the prescaler's internal count. This gives software an exact starting phase without any separate control for it.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 00h, and both the overflow pulse and the overflow flag are 0.
- R2: When `wr_en_i` is 1 on a clock edge, `wr_data_i` is loaded into the count. A load overrides any increment in that same cycle.
- R3: An increment from FFh makes the count 00h and raises `ovf_pulse_o` for exactly that one cycle. A load of any value never raises the pulse.
- R4: `ovf_flag_o` is set together with `ovf_pulse_o` and then stays 1 until `ovf_clr_i` is seen high on an edge. If set and clear arrive in the same cycle, the set wins.
- R5: With `src_ext_i`=0 the timer's source is `cyc_en_i`. With `src_ext_i`=1 the source is detected pin edges. The unselected source has no effect on the count.
- R6: `edge_fall_i`=0 counts rising edges of `ext_pin_i` and `edge_fall_i`=1 counts falling edges; the opposite edge is ignored. A pin change made before clock edge k shows in the count after edge k+2 (two synchronizer stages plus the counter register).
- R7: With `psc_to_wdt_i`=0 the count advances once per 2^(`psc_ratio_i`+1) source events (ratio code 0 gives /2, up to code 7 giving /256). The advance happens on the last event of each group.
- R8: With `psc_to_wdt_i`=1 the count advances on every source event. `wdt_tick_o` then pulses, in the same cycle, on every 2^(`psc_ratio_i`+1)-th `wdt_tick_i`. With `psc_to_wdt_i`=0, `wdt_tick_o` follows `wdt_tick_i` directly.
- R9: A counter load clears the prescaler count, so the next divided step comes a full division period after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | One-cycle strobe per instruction cycle |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| edge_fall_i | input | 1 | 0: rising edge, 1: falling edge |
| src_ext_i | input | 1 | 0: instruction cycle, 1: external pin |
| psc_to_wdt_i | input | 1 | 0: prescaler on the timer, 1: prescaler on the watchdog |
| psc_ratio_i | input | 3 | Division code n, giving a divide by 2^(n+1) |
| wdt_tick_i | input | 1 | Raw watchdog tick |
| wr_en_i | input | 1 | Counter load strobe |
| wr_data_i | input | 8 | Counter load value |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | 8 | Counter value |
| ovf_pulse_o | output | 1 | One-cycle wrap pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| wdt_tick_o | output | 1 | Watchdog tick, divided or passed through |

## Verification
A vector table runs the counting path under several combinations of routing bit, division code, preload value and event count. The results separate bypass mode from each division ratio, and a wrap from a run that stops just short of one. Directed cases then cover the following:
- A load and an event landing in the same cycle, which shows whether the load has priority.
- A load made in the middle of a division period, which shows whether the hidden prescaler count is cleared.
- Pin activity on both polarities, checked against the exact synchronizer latency, with instruction strobes sent while the pin is selected.
- Watchdog ticks under both routing settings.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} src_sel_e;
endpackage

// File: rtl/tt_pin_edge.sv
module tt_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  import tick_timer_pkg::*;

  // stages [0..SYNC_STAGES-1] synchronize, last bit holds previous sample
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], pin_i};
  end

  logic cur_s, prev_s;
  assign cur_s  = chain_q[SYNC_STAGES-1];
  assign prev_s = chain_q[SYNC_STAGES];

  always_comb begin
    if (edge_sel_e'(fall_sel_i) == EDGE_FALL) edge_o = ~cur_s & prev_s;
    else                                      edge_o = cur_s & ~prev_s;
  end
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PSC_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] mask;

  // low (ratio+1) bits set: terminal count of a 2^(ratio+1) period
  always_comb begin
    for (int i = 0; i < PSC_W; i++) mask[i] = (i <= int'(ratio_i));
  end

  assign tick_o = tick_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tt_count_core.sv
module tt_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             inc_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_pulse_o,
  output logic             ovf_flag_o
);
  logic wrap_s;
  assign wrap_s = inc_i & ~wr_en_i & (count_o == {CNT_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o     <= '0;
      ovf_pulse_o <= 1'b0;
      ovf_flag_o  <= 1'b0;
    end else begin
      if (wr_en_i)    count_o <= wr_data_i;
      else if (inc_i) count_o <= count_o + 1'b1;
      ovf_pulse_o <= wrap_s;
      if (wrap_s)          ovf_flag_o <= 1'b1;
      else if (flag_clr_i) ovf_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W       = 8,
  parameter int PSC_W       = 8,
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cyc_en_i,
  input  logic               ext_pin_i,
  input  logic               edge_fall_i,
  input  logic               src_ext_i,
  input  logic               psc_to_wdt_i,
  input  logic [RATIO_W-1:0] psc_ratio_i,
  input  logic               wdt_tick_i,
  input  logic               wr_en_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  input  logic               ovf_clr_i,
  output logic [CNT_W-1:0]   count_o,
  output logic               ovf_pulse_o,
  output logic               ovf_flag_o,
  output logic               wdt_tick_o
);
  import tick_timer_pkg::*;

  logic pin_edge_s, src_tick_s, psc_in_s, psc_out_s, inc_s;

  tt_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .fall_sel_i (edge_fall_i),
    .edge_o     (pin_edge_s)
  );

  assign src_tick_s = (src_sel_e'(src_ext_i) == SRC_PIN) ? pin_edge_s : cyc_en_i;

  // one divider, routed to whichever side owns it
  assign psc_in_s = psc_to_wdt_i ? wdt_tick_i : src_tick_s;

  tt_prescaler #(.PSC_W(PSC_W), .RATIO_W(RATIO_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (psc_in_s),
    .clr_i   (wr_en_i),
    .ratio_i (psc_ratio_i),
    .tick_o  (psc_out_s)
  );

  assign inc_s      = psc_to_wdt_i ? src_tick_s : psc_out_s;
  assign wdt_tick_o = psc_to_wdt_i ? psc_out_s  : wdt_tick_i;

  tt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .inc_i       (inc_s),
    .flag_clr_i  (ovf_clr_i),
    .count_o     (count_o),
    .ovf_pulse_o (ovf_pulse_o),
    .ovf_flag_o  (ovf_flag_o)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             src_ext_i,
  input logic             wdt_tick_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_pulse_o,
  input logic             ovf_flag_o,
  input logic             wdt_tick_o
);
  AST_WR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> count_o == $past(wr_data_i)); // R2
  AST_PULSE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |-> count_o == '0); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |=> !ovf_pulse_o); // R3
  AST_NO_PULSE_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !ovf_pulse_o); // R3
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_pulse_o |-> ovf_flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ext_i && !cyc_en_i && !wr_en_i) |=> $stable(count_o)); // R5
  AST_WDT_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tick_o |-> wdt_tick_i); // R8
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_en_i    (cyc_en_i),
  .src_ext_i   (src_ext_i),
  .wdt_tick_i  (wdt_tick_i),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .ovf_clr_i   (ovf_clr_i),
  .count_o     (count_o),
  .ovf_pulse_o (ovf_pulse_o),
  .ovf_flag_o  (ovf_flag_o),
  .wdt_tick_o  (wdt_tick_o)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cyc_en_i = 1'b0, ext_pin_i = 1'b0, edge_fall_i = 1'b0, src_ext_i = 1'b0;
  logic       psc_to_wdt_i = 1'b0, wdt_tick_i = 1'b0, wr_en_i = 1'b0, ovf_clr_i = 1'b0;
  logic [2:0] psc_ratio_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] count_o;
  logic       ovf_pulse_o, ovf_flag_o, wdt_tick_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  tick_timer dut_i (.*);

  typedef struct packed {
    logic       bypass;
    logic [2:0] ratio;
    logic [7:0] preload;
    logic [9:0] ticks;
    logic [7:0] exp_cnt;
    logic       exp_flag;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 8'h0A, 10'd5,   8'h0F, 1'b0},  // R8 undivided
    '{1'b0, 3'd0, 8'h00, 10'd7,   8'h03, 1'b0},  // R7 /2
    '{1'b0, 3'd2, 8'h20, 10'd20,  8'h22, 1'b0},  // R7 /8
    '{1'b0, 3'd7, 8'h40, 10'd256, 8'h41, 1'b0},  // R7 /256
    '{1'b1, 3'd0, 8'hFE, 10'd3,   8'h01, 1'b1},  // R3 wrap
    '{1'b0, 3'd1, 8'hFF, 10'd3,   8'hFF, 1'b0}   // R7 /4 short of step
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc_tick();
    @(negedge clk_i) cyc_en_i = 1'b1;
    @(negedge clk_i) cyc_en_i = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    @(negedge clk_i) begin wr_en_i = 1'b1; wr_data_i = v; end
    @(negedge clk_i) wr_en_i = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk_i) ovf_clr_i = 1'b1;
    @(negedge clk_i) ovf_clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk_i);
    chk("R1 count", count_o, 8'h00);
    chk("R1 pulse", ovf_pulse_o, 1'b0);
    chk("R1 flag", ovf_flag_o, 1'b0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i) begin psc_to_wdt_i = VECS[v].bypass; psc_ratio_i = VECS[v].ratio; end
      load(VECS[v].preload);
      for (int t = 0; t < int'(VECS[v].ticks); t++) cyc_tick();
      chk($sformatf("R7 vector %0d count", v), count_o, VECS[v].exp_cnt);
      chk($sformatf("R4 vector %0d flag", v), ovf_flag_o, VECS[v].exp_flag);
      clr_flag();
    end

    // R3/R4: pulse timing and sticky flag
    @(negedge clk_i) psc_to_wdt_i = 1'b1;
    load(8'hFF);
    cyc_tick();
    chk("R3 count after wrap", count_o, 8'h00);
    chk("R3 pulse high", ovf_pulse_o, 1'b1);
    @(negedge clk_i);
    chk("R3 pulse one cycle", ovf_pulse_o, 1'b0);
    repeat (5) @(negedge clk_i);
    chk("R4 flag held", ovf_flag_o, 1'b1);
    clr_flag();
    chk("R4 flag cleared", ovf_flag_o, 1'b0);

    // R3: load of FFh then 00h raises no pulse
    load(8'hFF);
    chk("R3 no pulse on load", ovf_pulse_o, 1'b0);

    // R2: load beats same-cycle increment
    @(negedge clk_i) begin wr_en_i = 1'b1; wr_data_i = 8'h55; cyc_en_i = 1'b1; end
    @(negedge clk_i) begin wr_en_i = 1'b0; cyc_en_i = 1'b0; end
    chk("R2 load priority", count_o, 8'h55);

    // R9: load clears prescaler phase
    @(negedge clk_i) begin psc_to_wdt_i = 1'b0; psc_ratio_i = 3'd1; end
    load(8'h00);
    repeat (3) cyc_tick();
    chk("R9 before load", count_o, 8'h00);
    load(8'h10);
    cyc_tick();
    chk("R9 phase reset", count_o, 8'h10);
    repeat (3) cyc_tick();
    chk("R9 full period", count_o, 8'h11);

    // R5/R6: external pin source
    @(negedge clk_i) begin src_ext_i = 1'b1; psc_to_wdt_i = 1'b1; edge_fall_i = 1'b0; end
    load(8'h00);
    @(negedge clk_i) ext_pin_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R6 latency not yet", count_o, 8'h00);
    @(negedge clk_i);
    chk("R6 rising counted", count_o, 8'h01);
    @(negedge clk_i) ext_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R6 falling ignored", count_o, 8'h01);
    repeat (3) cyc_tick();
    chk("R5 cycle strobe ignored", count_o, 8'h01);
    @(negedge clk_i) edge_fall_i = 1'b1;
    @(negedge clk_i) ext_pin_i = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R6 rising ignored", count_o, 8'h01);
    @(negedge clk_i) ext_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R6 falling counted", count_o, 8'h02);
    @(negedge clk_i) begin ext_pin_i = 1'b1; src_ext_i = 1'b0; end
    @(negedge clk_i) ext_pin_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R5 pin ignored", count_o, 8'h02);

    // R8: watchdog side of the prescaler
    @(negedge clk_i) begin psc_to_wdt_i = 1'b1; psc_ratio_i = 3'd1; end
    load(8'h00);
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i) wdt_tick_i = 1'b1;
      #1 if (wdt_tick_o) pulses++;
      @(negedge clk_i) wdt_tick_i = 1'b0;
    end
    chk("R8 wdt divided", pulses, 2);
    chk("R8 count untouched", count_o, 8'h00);
    @(negedge clk_i) begin psc_to_wdt_i = 1'b0; wdt_tick_i = 1'b1; end
    #1 chk("R8 wdt passthrough", wdt_tick_o, 1'b1);
    @(negedge clk_i) wdt_tick_i = 1'b0;
    #1 chk("R8 wdt passthrough low", wdt_tick_o, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule